// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces one interrupt flag for each side of a dual-port memory. The memory has 14-bit addresses and 9-bit words. The two highest word addresses act as mailboxes, one for each port:

- Port A owns the word just below the top (0x3FFE).
- Port B owns the top word (0x3FFF).

A port posts a message by writing the other port's mailbox. That write raises the interrupt of the receiving port. The receiving port acknowledges by reading its own mailbox, which releases the interrupt. The message itself lives in the ordinary memory array, which sits outside this block. This block only watches each port's enable, write strobe, output enable and address, so the mailbox words remain normal RAM whether or not the interrupts are used.

Each flag is a two-state machine with states QUIET and RAISED:
- QUIET goes to RAISED on a *post* (a peer write to the mailbox).
- RAISED goes to QUIET on an *acknowledge* (an owner access to the mailbox with output enable active), unless a post arrives in the same cycle.
- A post with no acknowledge holds RAISED, and all other activity holds the current state.

The flags are registered, so an interrupt pin changes one clock after the access that causes it. The parameter `MBOX_EN` removes the function entirely and leaves both interrupt lines high.

Top module: `mbx_irq_pair`

## Requirements
- R1: After reset, and whenever `rst_n` is low, `a_irq_n` and `b_irq_n` are both 1 (deasserted).
- R2: A port B access with `b_en`=1, `b_wr`=1 and `b_addr`=0x3FFE drives `a_irq_n` to 0 one clock later.
- R3: A port A access with `a_en`=1, `a_oe`=1 and `a_addr`=0x3FFE returns `a_irq_n` to 1 one clock later, whatever the value of `a_wr`.
- R4: A port A access with `a_en`=1, `a_wr`=1 and `a_addr`=0x3FFF drives `b_irq_n` to 0 one clock later. A port B access with `b_en`=1, `b_oe`=1 and `b_addr`=0x3FFF returns `b_irq_n` to 1 one clock later.
- R5: When a post and an acknowledge of the same flag fall in the same cycle, the flag is 0 one clock later.
- R6: All other accesses leave both flags unchanged. This includes a write by a port to its own mailbox without output enable, reads of a mailbox by the peer port, accesses to other addresses, and strobes while the port enable is 0.
- R7: With `MBOX_EN`=0, both interrupt outputs stay 1 under any traffic.
- R8: The two flags are independent: both can be 0 at the same time, and acknowledging one does not alter the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_en | input | 1 | Port A enable, active high |
| a_wr | input | 1 | Port A write strobe, active high |
| a_oe | input | 1 | Port A output enable, active high |
| a_addr | input | 14 | Port A word address |
| b_en | input | 1 | Port B enable, active high |
| b_wr | input | 1 | Port B write strobe, active high |
| b_oe | input | 1 | Port B output enable, active high |
| b_addr | input | 14 | Port B word address |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
The main vector walk sends posts and acknowledges through both flags. Around them it places near misses:
- a write to the port's own mailbox without output enable, which distinguishes a write-qualified clear from an output-enable-qualified one;
- a neighbouring address (0x3FFD);
- a disabled port carrying active strobes;
- a peer reading the wrong mailbox, which exposes swapped mailbox addresses.

Two vectors put a post and an acknowledge of the same flag in one cycle, which separates set priority from clear priority. Directed tests apply reset while a flag is pending, and drive a second instance built with the function disabled.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } flag_state_e;
endpackage

// File: rtl/mbx_port_decode.sv
// Watches one port and reports two events:
//   ack_own   - an access to the port's own mailbox with output enable active
//   post_peer - a write to the peer port's mailbox
module mbx_port_decode #(
    parameter int ADDR_W = 14,
    parameter logic [ADDR_W-1:0] OWN_SLOT  = '1,
    parameter logic [ADDR_W-1:0] PEER_SLOT = '0
) (
    input  logic              en,
    input  logic              wr,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    output logic              ack_own,
    output logic              post_peer
);
    logic hit_own;
    logic hit_peer;

    always_comb begin
        hit_own   = (addr == OWN_SLOT);
        hit_peer  = (addr == PEER_SLOT);
        // The write strobe plays no part in the acknowledge.
        ack_own   = en && oe && hit_own;
        post_peer = en && wr && hit_peer;
    end
endmodule

// File: rtl/mbx_flag_fsm.sv
// One interrupt flag: QUIET <-> RAISED. A post takes priority over an acknowledge.
module mbx_flag_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic post,
    input  logic ack,
    output logic irq_n
);
    flag_state_e state;
    flag_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_QUIET:  if (post)         state_nxt = ST_RAISED;
            ST_RAISED: if (ack && !post) state_nxt = ST_QUIET;
            default:                     state_nxt = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= state_nxt;
    end

    always_comb begin
        irq_n = (state != ST_RAISED);
    end

    AST_POST_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> !irq_n); // R2

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !post) |=> irq_n); // R3

    AST_POST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && post) |=> !irq_n); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !post) |=> $stable(irq_n)); // R6
endmodule

// File: rtl/mbx_irq_pair.sv
module mbx_irq_pair #(
    parameter int ADDR_W  = 14,
    parameter bit MBOX_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic              a_oe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic              b_oe,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_irq_n,
    output logic              b_irq_n
);
    localparam logic [ADDR_W-1:0] TOP_WORD = '1;
    localparam logic [ADDR_W-1:0] A_BOX    = TOP_WORD - 1'b1;
    localparam logic [ADDR_W-1:0] B_BOX    = TOP_WORD;

    generate
        if (MBOX_EN) begin : g_on
            logic a_ack, b_ack, a_post, b_post;

            // Port A acknowledges its own box and posts into B's box.
            mbx_port_decode #(.ADDR_W(ADDR_W), .OWN_SLOT(A_BOX), .PEER_SLOT(B_BOX)) u_dec_a (
                .en(a_en), .wr(a_wr), .oe(a_oe), .addr(a_addr),
                .ack_own(a_ack), .post_peer(b_post)
            );
            // Port B acknowledges its own box and posts into A's box.
            mbx_port_decode #(.ADDR_W(ADDR_W), .OWN_SLOT(B_BOX), .PEER_SLOT(A_BOX)) u_dec_b (
                .en(b_en), .wr(b_wr), .oe(b_oe), .addr(b_addr),
                .ack_own(b_ack), .post_peer(a_post)
            );

            mbx_flag_fsm u_flag_a (
                .clk(clk), .rst_n(rst_n), .post(a_post), .ack(a_ack), .irq_n(a_irq_n)
            );
            mbx_flag_fsm u_flag_b (
                .clk(clk), .rst_n(rst_n), .post(b_post), .ack(b_ack), .irq_n(b_irq_n)
            );
        end else begin : g_off
            assign a_irq_n = 1'b1;
            assign b_irq_n = 1'b1;
        end
    endgenerate
endmodule

// File: tb/sim_mbx_irq_pair.sv
module sim_mbx_irq_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_en = 0, a_wr = 0, a_oe = 0;
    logic        b_en = 0, b_wr = 0, b_oe = 0;
    logic [13:0] a_addr = '0, b_addr = '0;
    logic        a_irq_n, b_irq_n, a_off_n, b_off_n;
    int          errors = 0;
    int          checks = 0;

    always #10 clk = ~clk;  // 50 MHz

    mbx_irq_pair u0 (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_wr(a_wr), .a_oe(a_oe), .a_addr(a_addr),
        .b_en(b_en), .b_wr(b_wr), .b_oe(b_oe), .b_addr(b_addr),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
    );

    mbx_irq_pair #(.MBOX_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_wr(a_wr), .a_oe(a_oe), .a_addr(a_addr),
        .b_en(b_en), .b_wr(b_wr), .b_oe(b_oe), .b_addr(b_addr),
        .a_irq_n(a_off_n), .b_irq_n(b_off_n)
    );

    typedef struct packed {
        logic [2:0]  pa;    // {en, wr, oe} on port A
        logic [13:0] aa;
        logic [2:0]  pb;    // {en, wr, oe} on port B
        logic [13:0] ab;
        logic        ea;    // expected a_irq_n after the clock
        logic        eb;    // expected b_irq_n after the clock
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [0:NV-1] = '{
        '{3'b000, 14'h0000, 3'b000, 14'h0000, 1'b1, 1'b1}, // 0 idle             R6
        '{3'b000, 14'h0000, 3'b110, 14'h3FFE, 1'b0, 1'b1}, // 1 B posts A        R2
        '{3'b000, 14'h0000, 3'b110, 14'h3FFF, 1'b0, 1'b1}, // 2 B writes own box R6
        '{3'b110, 14'h3FFE, 3'b000, 14'h0000, 1'b0, 1'b1}, // 3 A write, no oe   R6
        '{3'b101, 14'h3FFD, 3'b000, 14'h0000, 1'b0, 1'b1}, // 4 A reads neighbor R6
        '{3'b011, 14'h3FFE, 3'b000, 14'h0000, 1'b0, 1'b1}, // 5 A disabled       R6
        '{3'b111, 14'h3FFE, 3'b000, 14'h0000, 1'b1, 1'b1}, // 6 A ack, wr=1      R3
        '{3'b110, 14'h3FFF, 3'b000, 14'h0000, 1'b1, 1'b0}, // 7 A posts B        R4
        '{3'b101, 14'h3FFE, 3'b110, 14'h3FFE, 1'b0, 1'b0}, // 8 post+ack on A    R5 R8
        '{3'b000, 14'h0000, 3'b101, 14'h3FFF, 1'b0, 1'b1}, // 9 B ack            R4 R8
        '{3'b101, 14'h3FFE, 3'b000, 14'h0000, 1'b1, 1'b1}, // 10 A ack           R3
        '{3'b110, 14'h3FFF, 3'b101, 14'h3FFF, 1'b1, 1'b0}, // 11 post+ack on B   R5
        '{3'b000, 14'h0000, 3'b101, 14'h3FFE, 1'b1, 1'b0}, // 12 B reads A's box R6
        '{3'b000, 14'h0000, 3'b101, 14'h3FFF, 1'b1, 1'b1}  // 13 B ack           R4
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] pa, input logic [13:0] aa,
                         input logic [2:0] pb, input logic [13:0] ab);
        {a_en, a_wr, a_oe} = pa; a_addr = aa;
        {b_en, b_wr, b_oe} = pb; b_addr = ab;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 a reset", a_irq_n, 1'b1);
        check("R1 b reset", b_irq_n, 1'b1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i].pa, TBL[i].aa, TBL[i].pb, TBL[i].ab);
            @(negedge clk);
            check($sformatf("R2-R6 vec%0d a", i), a_irq_n, TBL[i].ea);
            check($sformatf("R2-R6 vec%0d b", i), b_irq_n, TBL[i].eb);
            check("R7 off a", a_off_n, 1'b1);
            check("R7 off b", b_off_n, 1'b1);
        end

        // R8: both pending at once, then reset releases both (R1)
        drive(3'b110, 14'h3FFF, 3'b110, 14'h3FFE);
        @(negedge clk);
        check("R8 a pending", a_irq_n, 1'b0);
        check("R8 b pending", b_irq_n, 1'b0);
        drive(3'b000, 14'h0, 3'b000, 14'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 a mid reset", a_irq_n, 1'b1);
        check("R1 b mid reset", b_irq_n, 1'b1);
        // R1: a post during reset has no effect
        drive(3'b000, 14'h0, 3'b110, 14'h3FFE);
        @(negedge clk);
        check("R1 post in reset", a_irq_n, 1'b1);
        drive(3'b000, 14'h0, 3'b000, 14'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", a_irq_n, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule